// File: doc/BRIEF.md
# Compare and Test Flag Unit

This unit evaluates compare-class operations on two 32-bit operands and keeps only the condition flags. The operations are: subtract a register, subtract an 8-bit immediate, add a register (negative compare), and bitwise AND (test). The numeric result stays inside the unit. A four-bit status register holds negative, zero, carry and overflow, and the conditional branch and predication logic downstream reads it.

An operation is presented with its operands and a one-cycle valid strobe. The flags change on that clock edge. With no strobe, the status register holds its value. Subtraction is formed as the first operand plus the inverted second operand plus one. Carry after a compare therefore means that no borrow occurred.

Top module: `cmpflag_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four flags become 0 at that edge.
- R2: At an edge where `valid` is low, all four flags keep their previous values, whatever the other inputs carry.
- R3: Operation code 2'b01 (register compare) evaluates `opa - opb`. C is 1 exactly when `opa >= opb` as unsigned numbers. V is 1 when the signed difference overflows.
- R4: Operation code 2'b00 (immediate compare) evaluates `opa` minus `imm` zero-extended to 32 bits. `opb` has no effect. C and V follow the same rules as in R3.
- R5: Operation code 2'b10 (negative compare) evaluates `opa + opb`. C is the carry out of bit 31. V is 1 when both addends have the same sign and the sum has the other sign.
- R6: Operation code 2'b11 (test) evaluates `opa & opb`. It updates N and Z only. C and V keep their previous values.
- R7: Z is 1 exactly when the 32-bit result of the operation is zero. For a compare, this means the two compared values are equal.
- R8: N equals bit 31 of the 32-bit result.
- R9: Some results are fixed by example. 0x7FFFFFFF + 1 gives V=1 and C=0. 0x80000000 + 0x80000000 gives C=1, V=1 and Z=1. 0x10 - 0x01 gives C=1.
- R10: Flags take new values on the rising edge where `valid` is high and are visible immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid | input | 1 | Strobe: evaluate the operation on this edge |
| op | input | 2 | Operation code (00 imm compare, 01 reg compare, 10 negative compare, 11 test) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second register operand |
| imm | input | 8 | Immediate for the immediate compare |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Uniform random 32-bit operands almost never produce a zero result or a signed overflow at the boundary. The stimulus therefore mixes directed edge values into the random operands: equal pairs, 0x7FFFFFFF, 0x80000000, 0 and all-ones. The hardest case is showing that a test operation leaves C and V alone. That only means something when C and V are already nonzero. The bench therefore places test operations directly after arithmetic operations that set carry or overflow, and compares all four flags against a running model.

// File: rtl/cmpflag_pkg.sv
// Package: shared operation encoding for the compare and test flag unit.
// Assumes a two-bit operation code supplied by an upstream decoder.
package cmpflag_pkg;

    typedef enum logic [1:0] {
        OP_CMP_IMM = 2'b00,
        OP_CMP_REG = 2'b01,
        OP_CMP_NEG = 2'b10,
        OP_TEST    = 2'b11
    } cf_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cf_flags_t;

endpackage

// File: rtl/cmpflag_opsel.sv
// Operand selector: picks the second operand (register or zero-extended
// immediate) and decodes the operation into subtract / logic controls.
// Assumes IMM_W <= DATA_W.
module cmpflag_opsel
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] src_b,
    output logic              do_sub,
    output logic              do_logic
);

    localparam int PAD_W = DATA_W - IMM_W;

    cf_op_e            op_q;
    logic [DATA_W-1:0] imm_ext;

    assign op_q = cf_op_e'(op);

    // Zero-extend the immediate; width difference chosen at elaboration.
    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm};
        end else begin : g_nopad
            assign imm_ext = imm;
        end
    endgenerate

    // Decode the operation into operand choice and datapath mode.
    always_comb begin
        src_b    = opb;
        do_sub   = 1'b0;
        do_logic = 1'b0;
        unique case (op_q)
            OP_CMP_IMM: begin src_b = imm_ext; do_sub = 1'b1; end
            OP_CMP_REG: do_sub   = 1'b1;
            OP_CMP_NEG: do_sub   = 1'b0;
            OP_TEST:    do_logic = 1'b1;
            default:    do_sub   = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpflag_alu.sv
// Flag datapath: one adder serves add and subtract (subtract = a + ~b + 1),
// plus a bitwise AND path; produces next N/Z/C/V. The result is not exported.
module cmpflag_alu
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              do_sub,
    input  logic              do_logic,
    output cf_flags_t         nxt
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] res;

    // Invert the second operand for subtraction.
    assign b_eff = do_sub ? ~src_b : src_b;

    // Shared adder with carry-in for the two's complement subtract.
    assign sum = {1'b0, src_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};

    // Pick arithmetic or logical result.
    assign res = do_logic ? (src_a & src_b) : sum[MSB:0];

    // Derive the four flags from the selected result.
    always_comb begin
        nxt.n = res[MSB];
        nxt.z = (res == '0);
        nxt.c = sum[DATA_W];
        nxt.v = (src_a[MSB] == b_eff[MSB]) && (sum[MSB] != src_a[MSB]);
    end

endmodule

// File: rtl/cmpflag_reg.sv
// Status register: loads N/Z on every valid operation and C/V only on
// arithmetic ones; synchronous active-low reset to zero.
module cmpflag_reg
    import cmpflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  logic      do_logic,
    input  cf_flags_t nxt,
    output cf_flags_t flags
);

    // Update the flags on a strobed edge, keeping carry/overflow for tests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (valid) begin
            flags.n <= nxt.n;
            flags.z <= nxt.z;
            if (!do_logic) begin
                flags.c <= nxt.c;
                flags.v <= nxt.v;
            end
        end
    end

endmodule

// File: rtl/cmpflag_unit.sv
// Top: compare and test flag unit. Evaluates a compare-class operation,
// drops the numeric result and registers N/Z/C/V. Assumes op is stable
// while valid is high at the clock edge.
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    logic [DATA_W-1:0] src_b;
    logic              do_sub;
    logic              do_logic;
    cf_flags_t         nxt;
    cf_flags_t         flags;

    cmpflag_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .op(op), .opb(opb), .imm(imm),
        .src_b(src_b), .do_sub(do_sub), .do_logic(do_logic)
    );

    cmpflag_alu #(.DATA_W(DATA_W)) u_alu (
        .src_a(opa), .src_b(src_b), .do_sub(do_sub),
        .do_logic(do_logic), .nxt(nxt)
    );

    cmpflag_reg u_reg (
        .clk(clk), .rst_n(rst_n), .valid(valid),
        .do_logic(do_logic), .nxt(nxt), .flags(flags)
    );

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;

endmodule

// File: rtl/cmpflag_unit_chk.sv
// Checker: port-level temporal properties of the flag unit, bound to the top.
module cmpflag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [1:0]        op,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [IMM_W-1:0]  imm,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    localparam int PAD_W = DATA_W - IMM_W;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> {flag_n, flag_z, flag_c, flag_v} == 4'b0000);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    a_r6_test_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'b11) |=> $stable({flag_c, flag_v}));

    a_r3_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'b01) |=> flag_c == ($past(opa) >= $past(opb)));

    a_r7_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'b01) |=> flag_z == ($past(opa) == $past(opb)));

    a_r4_imm_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'b00) |=>
            flag_c == ($past(opa) >= {{PAD_W{1'b0}}, $past(imm)}));

    a_r5_neg_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'b10) |=> flag_c == ($past(opa) > ~$past(opb)));

endmodule

bind cmpflag_unit cmpflag_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .opa(opa),
    .opb(opb), .imm(imm), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/sim_cmpflag_unit.sv
`timescale 1ns/1ps
module sim_cmpflag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [7:0]  imm = '0;
    logic        flag_n, flag_z, flag_c, flag_v;

    int          n_vec = 0;
    int          n_err = 0;
    logic [3:0]  model = 4'b0000;   // {n,z,c,v}

    always #4 clk = ~clk;  // 125 MHz

    cmpflag_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .opa(opa),
        .opb(opb), .imm(imm), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    // Expected flags from the requirements, given previous flags.
    function automatic logic [3:0] expect_flags(input logic [1:0] o,
            input logic [31:0] a, input logic [31:0] b,
            input logic [7:0] i, input logic [3:0] prev);
        logic [32:0] wide;
        logic [31:0] r;
        logic        c, v;
        case (o)
            2'b00: begin
                wide = {1'b0, a} - {25'b0, i};
                r = wide[31:0]; c = (a >= {24'b0, i});
                v = (a[31] != 1'b0) && (r[31] != a[31]);
            end
            2'b01: begin
                r = a - b; c = (a >= b);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            2'b10: begin
                wide = {1'b0, a} + {1'b0, b};
                r = wide[31:0]; c = wide[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            default: begin
                r = a & b; c = prev[1]; v = prev[0];
            end
        endcase
        return {r[31], (r == 32'd0), c, v};
    endfunction

    function automatic string tag_of(input logic [1:0] o);
        case (o)
            2'b00:   return "R4 imm-compare";
            2'b01:   return "R3 reg-compare";
            2'b10:   return "R5 neg-compare";
            default: return "R6 test";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {flag_n, flag_z, flag_c, flag_v};
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: nzcv actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check at the next falling edge (R10).
    task automatic apply(input logic v_in, input logic [1:0] o,
            input logic [31:0] a, input logic [31:0] b, input logic [7:0] i,
            input string extra);
        @(negedge clk);
        valid = v_in; op = o; opa = a; opb = b; imm = i;
        if (v_in) model = expect_flags(o, a, b, i, model);
        @(negedge clk);
        valid = 1'b0;
        if (v_in)
            check({tag_of(o), " R7 R8 R10 ", extra}, model);
        else
            check({"R2 idle hold ", extra}, model);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h0000_0001;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 4'b0000);
        rst_n = 1'b1;

        // R9 directed examples
        apply(1, 2'b10, 32'h7FFF_FFFF, 32'h1, 8'h0, "R9 max+1");
        apply(1, 2'b10, 32'h8000_0000, 32'h8000_0000, 8'h0, "R9 min+min");
        apply(1, 2'b01, 32'h10, 32'h01, 8'h0, "R9 0x10-1");
        // R6 test after carry/overflow set
        apply(1, 2'b10, 32'h8000_0000, 32'h8000_0000, 8'h0, "setup");
        apply(1, 2'b11, 32'hF000_0000, 32'h8000_0001, 8'h0, "keeps C V");
        apply(1, 2'b11, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 8'h0, "zero and");
        // R4 immediate edges, opb ignored
        apply(1, 2'b00, 32'h0000_00FF, 32'hDEAD_BEEF, 8'hFF, "equal imm");
        apply(1, 2'b00, 32'h0000_0000, 32'h0, 8'h01, "borrow");
        apply(1, 2'b00, 32'h8000_0000, 32'h1234_5678, 8'h01, "signed ovf");
        // R3 signed overflow and equality
        apply(1, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 8'h0, "pos-neg ovf");
        apply(1, 2'b01, 32'h1234_5678, 32'h1234_5678, 8'h0, "equal");
        // R2 idle with junk inputs
        apply(0, 2'b01, 32'h0, 32'h1, 8'h0, "after eq");
        // R1 mid-run reset
        @(negedge clk); rst_n = 1'b0; valid = 1'b1; op = 2'b01;
        @(negedge clk); model = 4'b0000; check("R1 reset with valid", model);
        rst_n = 1'b1; valid = 1'b0;

        for (int k = 0; k < 600; k++) begin
            apply(($urandom_range(0, 5) != 0), 2'($urandom_range(0, 3)),
                  pick_val(), pick_val(), 8'($urandom()), "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule